// File: doc/BRIEF.md
# CAN Fault-Confinement State Classifier

This block turns a CAN controller's 8-bit error-flag byte into a fault-confinement state. It acts only when a sample strobe arrives. On an accepted strobe it settles the flags into one of four states, each chosen by a fixed priority. It reports which flag won, and it raises a one-cycle event when the state moves. It also keeps saturating statistics counters. On an upward jump the warning and passive counters each count every level that the jump crosses, so a jump straight from active to bus-off advances both of them.

The same strobe also samples the two receive-overflow bits. Each overflow bit that is set adds one to an overflow counter. One cycle later a two-bit clear pulse tells the controller to drop those bits.

If the block enters bus-off while automatic restart is disabled, it counts a bus-off event and latches a halt output. While halted it ignores every strobe. A synchronous clear input returns the state to active, releases the halt and zeroes all counters. The error counters themselves and all bus traffic lie outside this block.

The state machine has four states, all named by their encoding:
- ACTIVE = 0
- WARNING = 1
- PASSIVE = 2
- BUSOFF = 3

On an accepted strobe the machine moves from its current state to the resolved level. That level can be the same state (hold), a higher state (escalate: ACTIVE to WARNING, PASSIVE or BUSOFF; WARNING to PASSIVE or BUSOFF; PASSIVE to BUSOFF) or a lower state (recover: any state back to a lower one). Clear and reset force ACTIVE.

Top module: `can_fault_classifier`

## Requirements
- R1: After reset, `state` is 0 (ACTIVE), and `cause`, `state_chg`, `halt`, `ovf_clr` and all counters are 0.
- R2: The state is encoded as ACTIVE=0, WARNING=1, PASSIVE=2, BUSOFF=3. It changes only on a clock edge where `sample`=1 (or `clr`, or reset). Its new value is visible in the cycle after that edge.
- R3: The flag bits are: bit0 warning summary, bit1 RX warning, bit2 TX warning, bit3 RX passive, bit4 TX passive, bit5 bus-off, bit6 RX0 overflow, bit7 RX1 overflow. The level is resolved in this priority order: bus-off (BUSOFF), TX passive, RX passive (PASSIVE), TX warning, RX warning (WARNING). If none of these is set, the level is ACTIVE. Bit0 has no effect on the level.
- R4: `cause` is one-hot or zero and names the winning flag: bit0 RX warning, bit1 TX warning, bit2 RX passive, bit3 TX passive, bit4 bus-off. It is zero when the level is ACTIVE.
- R5: `state_chg` is high for exactly the one cycle after an accepted strobe that changed the state.
- R6: An accepted strobe that moves the state from ACTIVE to any higher state adds one to `warn_cnt`.
- R7: An accepted strobe that moves the state from ACTIVE or WARNING to PASSIVE or BUSOFF adds one to `pass_cnt`. A jump from ACTIVE therefore advances both counters.
- R8: On an accepted strobe, `ovf_cnt` grows by the number of set bits among bit6 and bit7.
- R9: In the cycle after an accepted strobe, `ovf_clr` equals the sampled flag bits {bit7, bit6}. Otherwise `ovf_clr` is 0.
- R10: Entering BUSOFF with `auto_restart`=0 adds one to `boff_cnt` and sets `halt`. Entering BUSOFF with `auto_restart`=1 does neither.
- R11: While `halt` is 1, strobes are ignored: the state, `cause` and the counters hold, and `state_chg` and `ovf_clr` stay 0.
- R12: `clr`=1 at a clock edge zeroes all counters, sets the state to ACTIVE, and clears `cause` and `halt`. It takes priority over a strobe in the same cycle.
- R13: Every counter saturates at all ones (2^CNT_W-1) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Synchronous clear of state, halt and counters |
| sample | input | 1 | Strobe: evaluate `err_flags` on this edge |
| err_flags | input | 8 | Controller error-flag byte |
| auto_restart | input | 1 | 1 = automatic bus-off recovery enabled |
| state | output | 2 | Fault-confinement state code |
| cause | output | 5 | One-hot winning flag of the last accepted strobe |
| state_chg | output | 1 | One-cycle pulse: the state changed |
| halt | output | 1 | Latched: bus-off reached without auto-restart |
| ovf_clr | output | 2 | One-cycle request to clear overflow bits {RX1, RX0} |
| warn_cnt | output | CNT_W | Escalations out of ACTIVE |
| pass_cnt | output | CNT_W | Escalations into PASSIVE or above |
| boff_cnt | output | CNT_W | Bus-off entries without auto-restart |
| ovf_cnt | output | CNT_W | Receive overflows seen |

## Verification
All results are registered. `state`, `cause`, the counters and `halt` take their new values at the edge where the strobe is high. The pulses `state_chg` and `ovf_clr` are valid only during the one cycle after that edge.

The bench drives each strobe on a falling edge and drops it on the next falling edge. It checks every output at that second falling edge, which lies inside the single cycle in which the pulses are valid. Steps that expect no strobe to take effect (held flags, halt, clear together with a strobe) are checked the same way one cycle later. This confirms that nothing moved.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;

    typedef enum logic [1:0] {
        FS_ACTIVE  = 2'd0,
        FS_WARNING = 2'd1,
        FS_PASSIVE = 2'd2,
        FS_BUSOFF  = 2'd3
    } fault_state_e;

    // Flag byte bit positions
    localparam int FLG_W       = 8;
    localparam int FB_RX_WARN  = 1;
    localparam int FB_TX_WARN  = 2;
    localparam int FB_RX_PASV  = 3;
    localparam int FB_TX_PASV  = 4;
    localparam int FB_BUSOFF   = 5;
    localparam int FB_OVF0     = 6;
    localparam int FB_OVF1     = 7;

    // Cause vector bit positions
    localparam int CAUSE_W     = 5;
    localparam int CZ_RX_WARN  = 0;
    localparam int CZ_TX_WARN  = 1;
    localparam int CZ_RX_PASV  = 2;
    localparam int CZ_TX_PASV  = 3;
    localparam int CZ_BUSOFF   = 4;

endpackage

// File: rtl/flag_resolver.sv
module flag_resolver
    import can_fault_pkg::*;
(
    input  logic [FLG_W-1:0]   flags,
    output fault_state_e       level,
    output logic [CAUSE_W-1:0] cause
);

    always_comb begin
        cause = '0;
        level = FS_ACTIVE;
        if (flags[FB_BUSOFF]) begin
            level              = FS_BUSOFF;
            cause[CZ_BUSOFF]   = 1'b1;
        end else if (flags[FB_TX_PASV]) begin
            level              = FS_PASSIVE;
            cause[CZ_TX_PASV]  = 1'b1;
        end else if (flags[FB_RX_PASV]) begin
            level              = FS_PASSIVE;
            cause[CZ_RX_PASV]  = 1'b1;
        end else if (flags[FB_TX_WARN]) begin
            level              = FS_WARNING;
            cause[CZ_TX_WARN]  = 1'b1;
        end else if (flags[FB_RX_WARN]) begin
            level              = FS_WARNING;
            cause[CZ_RX_WARN]  = 1'b1;
        end
    end

endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W      = 16,
    parameter int STEP_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [STEP_W-1:0] step,
    output logic [W-1:0]      count
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, count} + {{(SUM_W-STEP_W){1'b0}}, step};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (sum[W]) begin
            count <= '1;
        end else begin
            count <= sum[W-1:0];
        end
    end

endmodule

// File: rtl/fault_fsm.sv
module fault_fsm
    import can_fault_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               sample,
    input  logic               auto_restart,
    input  fault_state_e       level,
    input  logic [CAUSE_W-1:0] level_cause,
    input  logic [1:0]         ovf_bits,
    output fault_state_e       state_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               chg_q,
    output logic               halt_q,
    output logic [1:0]         ovf_clr_q,
    output logic               accept,
    output logic               warn_inc,
    output logic               pass_inc,
    output logic               boff_inc
);

    fault_state_e state_d;

    assign accept = sample && !halt_q && !clr;

    // Next state and transition classification
    always_comb begin
        state_d  = state_q;
        warn_inc = 1'b0;
        pass_inc = 1'b0;
        boff_inc = 1'b0;
        if (accept) begin
            state_d = level;
            unique case (state_q)
                FS_ACTIVE: begin
                    warn_inc = (level != FS_ACTIVE);
                    pass_inc = (level == FS_PASSIVE) || (level == FS_BUSOFF);
                    boff_inc = (level == FS_BUSOFF) && !auto_restart;
                end
                FS_WARNING: begin
                    pass_inc = (level == FS_PASSIVE) || (level == FS_BUSOFF);
                    boff_inc = (level == FS_BUSOFF) && !auto_restart;
                end
                FS_PASSIVE: begin
                    boff_inc = (level == FS_BUSOFF) && !auto_restart;
                end
                FS_BUSOFF: begin
                    boff_inc = 1'b0;
                end
                default: begin
                    boff_inc = 1'b0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_ACTIVE;
        end else if (clr) begin
            state_q <= FS_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q   <= '0;
            chg_q     <= 1'b0;
            halt_q    <= 1'b0;
            ovf_clr_q <= '0;
        end else if (clr) begin
            cause_q   <= '0;
            chg_q     <= 1'b0;
            halt_q    <= 1'b0;
            ovf_clr_q <= '0;
        end else begin
            chg_q     <= accept && (state_d != state_q);
            ovf_clr_q <= accept ? ovf_bits : 2'b00;
            if (accept) begin
                cause_q <= level_cause;
            end
            if (boff_inc) begin
                halt_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_fault_classifier.sv
module can_fault_classifier
    import can_fault_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               sample,
    input  logic [7:0]         err_flags,
    input  logic               auto_restart,
    output logic [1:0]         state,
    output logic [4:0]         cause,
    output logic               state_chg,
    output logic               halt,
    output logic [1:0]         ovf_clr,
    output logic [CNT_W-1:0]   warn_cnt,
    output logic [CNT_W-1:0]   pass_cnt,
    output logic [CNT_W-1:0]   boff_cnt,
    output logic [CNT_W-1:0]   ovf_cnt
);

    localparam int NUM_EV = 3;

    fault_state_e       level;
    logic [CAUSE_W-1:0] level_cause;
    fault_state_e       state_q;
    logic               accept;
    logic               warn_inc;
    logic               pass_inc;
    logic               boff_inc;
    logic [1:0]         ovf_bits;
    logic [1:0]         ovf_step;
    logic [NUM_EV-1:0]  ev_inc;
    logic [CNT_W-1:0]   ev_cnt [NUM_EV];

    assign ovf_bits = {err_flags[FB_OVF1], err_flags[FB_OVF0]};
    assign ovf_step = accept ? ({1'b0, ovf_bits[1]} + {1'b0, ovf_bits[0]}) : 2'd0;

    flag_resolver u_resolver (
        .flags (err_flags),
        .level (level),
        .cause (level_cause)
    );

    fault_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .sample       (sample),
        .auto_restart (auto_restart),
        .level        (level),
        .level_cause  (level_cause),
        .ovf_bits     (ovf_bits),
        .state_q      (state_q),
        .cause_q      (cause),
        .chg_q        (state_chg),
        .halt_q       (halt),
        .ovf_clr_q    (ovf_clr),
        .accept       (accept),
        .warn_inc     (warn_inc),
        .pass_inc     (pass_inc),
        .boff_inc     (boff_inc)
    );

    assign ev_inc = {boff_inc, pass_inc, warn_inc};

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        sat_counter #(.W(CNT_W), .STEP_W(1)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .step  (ev_inc[g]),
            .count (ev_cnt[g])
        );
    end

    sat_counter #(.W(CNT_W), .STEP_W(2)) u_ovf_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .step  (ovf_step),
        .count (ovf_cnt)
    );

    assign state    = state_q;
    assign warn_cnt = ev_cnt[0];
    assign pass_cnt = ev_cnt[1];
    assign boff_cnt = ev_cnt[2];

endmodule

// File: rtl/can_fault_classifier_chk.sv
module can_fault_classifier_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             sample,
    input logic [1:0]       state,
    input logic [4:0]       cause,
    input logic             state_chg,
    input logic             halt,
    input logic [1:0]       ovf_clr,
    input logic [CNT_W-1:0] warn_cnt,
    input logic [CNT_W-1:0] ovf_cnt
);

    // R2
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample && !clr) |=> $stable(state));

    // R4
    cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause));

    // R5
    chg_means_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !clr && !halt) |=> (state_chg == (state != $past(state))));

    // R9
    ovf_clr_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr != 2'b00) |-> $past(sample));

    // R10
    halt_in_busoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> (state == 2'd3));

    // R11
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> ($stable(state) && $stable(ovf_cnt) && !state_chg));

    // R13
    warn_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (warn_cnt >= $past(warn_cnt)));

endmodule

bind can_fault_classifier can_fault_classifier_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .sample    (sample),
    .state     (state),
    .cause     (cause),
    .state_chg (state_chg),
    .halt      (halt),
    .ovf_clr   (ovf_clr),
    .warn_cnt  (warn_cnt),
    .ovf_cnt   (ovf_cnt)
);

// File: tb/can_fault_classifier_bench.sv
module can_fault_classifier_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 13;
    localparam int WD_LIMIT   = 150000;

    typedef struct packed {
        logic [7:0] flags;
        logic       ar;
        logic [1:0] st;
        logic       chg;
        logic [4:0] cz;
        logic [3:0] w;
        logic [3:0] p;
        logic [3:0] b;
        logic [3:0] o;
        logic       hl;
        logic [1:0] oc;
    } vec_t;

    // Cumulative from reset: flags, auto_restart, state, chg, cause, warn, pass, boff, ovf, halt, ovf_clr
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 1'b1, 2'd0, 1'b0, 5'b00000, 4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h03, 1'b1, 2'd1, 1'b1, 5'b00001, 4'd1, 4'd0, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h04, 1'b1, 2'd1, 1'b0, 5'b00010, 4'd1, 4'd0, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h08, 1'b1, 2'd2, 1'b1, 5'b00100, 4'd1, 4'd1, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h00, 1'b1, 2'd0, 1'b1, 5'b00000, 4'd1, 4'd1, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h10, 1'b1, 2'd2, 1'b1, 5'b01000, 4'd2, 4'd2, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h1E, 1'b1, 2'd2, 1'b0, 5'b01000, 4'd2, 4'd2, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h01, 1'b1, 2'd0, 1'b1, 5'b00000, 4'd2, 4'd2, 4'd0, 4'd0, 1'b0, 2'b00},
        '{8'h40, 1'b1, 2'd0, 1'b0, 5'b00000, 4'd2, 4'd2, 4'd0, 4'd1, 1'b0, 2'b01},
        '{8'hC2, 1'b1, 2'd1, 1'b1, 5'b00001, 4'd3, 4'd2, 4'd0, 4'd3, 1'b0, 2'b11},
        '{8'h20, 1'b1, 2'd3, 1'b1, 5'b10000, 4'd3, 4'd3, 4'd0, 4'd3, 1'b0, 2'b00},
        '{8'h00, 1'b0, 2'd0, 1'b1, 5'b00000, 4'd3, 4'd3, 4'd0, 4'd3, 1'b0, 2'b00},
        '{8'h3F, 1'b0, 2'd3, 1'b1, 5'b10000, 4'd4, 4'd4, 4'd1, 4'd3, 1'b1, 2'b00}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clr = 1'b0;
    logic             sample = 1'b0;
    logic [7:0]       err_flags = 8'h00;
    logic             auto_restart = 1'b1;
    logic [1:0]       state;
    logic [4:0]       cause;
    logic             state_chg;
    logic             halt;
    logic [1:0]       ovf_clr;
    logic [CNT_W-1:0] warn_cnt;
    logic [CNT_W-1:0] pass_cnt;
    logic [CNT_W-1:0] boff_cnt;
    logic [CNT_W-1:0] ovf_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_fault_classifier #(.CNT_W(CNT_W)) u_can_fault_classifier (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .sample       (sample),
        .err_flags    (err_flags),
        .auto_restart (auto_restart),
        .state        (state),
        .cause        (cause),
        .state_chg    (state_chg),
        .halt         (halt),
        .ovf_clr      (ovf_clr),
        .warn_cnt     (warn_cnt),
        .pass_cnt     (pass_cnt),
        .boff_cnt     (boff_cnt),
        .ovf_cnt      (ovf_cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [1:0] st, input logic chg,
                             input logic [4:0] cz, input int w, input int p, input int b,
                             input int o, input logic hl, input logic [1:0] oc);
        check(req, "state",     int'(state),     int'(st));
        check(req, "state_chg", int'(state_chg), int'(chg));
        check(req, "cause",     int'(cause),     int'(cz));
        check(req, "warn_cnt",  int'(warn_cnt),  w);
        check(req, "pass_cnt",  int'(pass_cnt),  p);
        check(req, "boff_cnt",  int'(boff_cnt),  b);
        check(req, "ovf_cnt",   int'(ovf_cnt),   o);
        check(req, "halt",      int'(halt),      int'(hl));
        check(req, "ovf_clr",   int'(ovf_clr),   int'(oc));
    endtask

    // Strobe for one cycle; outputs are checked one falling edge later
    task automatic strobe(input logic [7:0] f, input logic ar);
        @(negedge clk);
        err_flags    = f;
        auto_restart = ar;
        sample       = 1'b1;
        @(negedge clk);
        sample       = 1'b0;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WD_LIMIT) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
                report();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check_all("R1", 2'd0, 1'b0, 5'b0, 0, 0, 0, 0, 1'b0, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4 R5 R6 R7 R8 R9 R10 table walk
        for (int i = 0; i < NVEC; i++) begin
            strobe(VECS[i].flags, VECS[i].ar);
            check_all($sformatf("R3-table[%0d]", i), VECS[i].st, VECS[i].chg, VECS[i].cz,
                      int'(VECS[i].w), int'(VECS[i].p), int'(VECS[i].b),
                      int'(VECS[i].o), VECS[i].hl, VECS[i].oc);
        end

        // R11: halted, a strobe with overflow and active flags is ignored
        strobe(8'hC0, 1'b1);
        check_all("R11", 2'd3, 1'b0, 5'b10000, 4, 4, 1, 3, 1'b1, 2'b00);

        // R12: clear returns everything to zero
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check_all("R12", 2'd0, 1'b0, 5'b0, 0, 0, 0, 0, 1'b0, 2'b00);

        // R12: clear wins over a simultaneous strobe
        @(negedge clk);
        clr = 1'b1;
        err_flags = 8'hE0;
        sample = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        sample = 1'b0;
        check_all("R12", 2'd0, 1'b0, 5'b0, 0, 0, 0, 0, 1'b0, 2'b00);

        // R2: flags without a strobe have no effect
        err_flags = 8'hFF;
        repeat (3) @(negedge clk);
        check_all("R2", 2'd0, 1'b0, 5'b0, 0, 0, 0, 0, 1'b0, 2'b00);

        // R2: one strobe, new state visible the following cycle
        strobe(8'h08, 1'b1);
        check("R2", "state", int'(state), 2);
        @(negedge clk);
        check("R5", "state_chg one cycle", int'(state_chg), 0);
        check("R9", "ovf_clr idle", int'(ovf_clr), 0);

        // R10: bus-off from passive with auto-restart disabled
        strobe(8'h20, 1'b0);
        check_all("R10", 2'd3, 1'b1, 5'b10000, 1, 1, 1, 0, 1'b1, 2'b00);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;

        // R13: overflow counter saturates at all ones
        @(negedge clk);
        err_flags = 8'hC0;
        auto_restart = 1'b1;
        sample = 1'b1;
        repeat (32768 + 4) @(negedge clk);
        sample = 1'b0;
        check("R13", "ovf_cnt saturated", int'(ovf_cnt), (1 << CNT_W) - 1);
        check("R8", "state stays active", int'(state), 0);

        report();
    end

endmodule